// File: doc/BRIEF.md
# Off-line start-up and brownout supervisor

This block decides when the power stage of an off-line converter may switch. It reads threshold flags that analog comparators and an RMS detector have already produced: line above the start level, line above the brownout level, line above the maximum level, bulk voltage at zero, and bias rail above its upper and above its lower threshold. Every flag is resynchronised to the block clock before use.

A four-state mode machine runs the sequence idle, start-up, running and brownout. Start-up needs an acceptable line and a charged bias rail, and it must finish within a bounded time. While running, a line sag is tolerated for a fixed time before drive is removed. A separate hysteresis loop on the bias-rail flags drives the gate of an external start-up transistor: low lets the transistor charge the bias rail, and high turns it off. The timer lengths are parameters that the block converts to clock cycles from the clock frequency.

Top module: `start_supervisor`

## Requirements
- R1: After reset `mode_o` is 0 (idle), `drive_en_o` is 0 and `bias_fet_o` is 0.
- R2: Each flag input passes through two flip-flops. A flag change made between two rising edges changes `mode_o` at the third rising edge after the change, and not before.
- R3: From idle the mode becomes 1 (start-up) when the synchronised start flag is high. This does not happen while the line-maximum flag and the bulk-zero flag are both high.
- R4: `bias_fet_o` goes high when the bias-upper flag is high. It goes low when the bias-lower flag is low and the upper flag is low. With only the lower flag high it holds its previous value.
- R5: From start-up the mode becomes 2 (running) when `bias_fet_o` is high, the start flag is high and start is not blocked as in R3. Running is never entered directly from idle.
- R6: If start-up lasts `STARTUP_MS` milliseconds of clock cycles without qualifying, the mode returns to 0 with drive off. Qualification then begins again from idle.
- R7: From running, a low brownout flag moves the mode to 3 (brownout).
- R8: In brownout, a high brownout flag returns the mode to 2 before the brownout timer ends.
- R9: After `BROWNOUT_US` microseconds of clock cycles spent continuously in brownout, the mode returns to 0.
- R10: `drive_en_o` is high exactly when the mode is 2 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | Line RMS above the start level |
| line_ok_i | input | 1 | Line RMS above the brownout level |
| line_high_i | input | 1 | Line RMS above the maximum level |
| bulk_zero_i | input | 1 | Bulk voltage still at zero |
| bias_hi_i | input | 1 | Bias rail above its upper threshold |
| bias_lo_i | input | 1 | Bias rail above its lower threshold |
| drive_en_o | output | 1 | Power stage switching allowed |
| bias_fet_o | output | 1 | Start-up transistor control, low enables the transistor |
| mode_o | output | 2 | Mode: 0 idle, 1 start-up, 2 running, 3 brownout |

## Verification
The bench builds the block with `CLK_HZ` = 10000, which gives a 6000-cycle start-up timeout and a 210-cycle brownout timeout. At these lengths the bench can run the full start-up expiry and its restart, and the full brownout expiry, cycle by cycle. The timeout edges land on exact cycles, so an off-by-one in either timer shows up. A short brownout that recovers is also checked against the same reference model.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_START = 2'd1,
    MODE_RUN   = 2'd2,
    MODE_BROWN = 2'd3
  } sup_mode_e;

  localparam int unsigned FLAG_N    = 6;
  localparam int unsigned F_START   = 0;
  localparam int unsigned F_OK      = 1;
  localparam int unsigned F_HIGH    = 2;
  localparam int unsigned F_BZERO   = 3;
  localparam int unsigned F_BIAS_HI = 4;
  localparam int unsigned F_BIAS_LO = 5;

  function automatic longint unsigned time_to_cyc(longint unsigned hz,
                                                  longint unsigned t,
                                                  longint unsigned per_s);
    return (hz * t) / per_s;
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sup_bias_hyst.sv
module sup_bias_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic above_hi_i,
  input  logic above_lo_i,
  output logic ctrl_o
);
  logic ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)          ctrl_q <= 1'b0;
    else if (above_hi_i)  ctrl_q <= 1'b1;
    else if (!above_lo_i) ctrl_q <= 1'b0;

  assign ctrl_o = ctrl_q;

  // band between thresholds keeps last decision
  assert_band_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (above_lo_i && !above_hi_i) |=> $stable(ctrl_q));
  assert_fall_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!above_lo_i && !above_hi_i) |=> !ctrl_q);
  assert_rise_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    above_hi_i |=> ctrl_q);
endmodule

// File: rtl/sup_timer.sv
module sup_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);

  assign done_o = (cnt_q == lim_i - W'(1));

  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |-> (cnt_q < lim_i));
endmodule

// File: rtl/start_supervisor.sv
module start_supervisor
  import sup_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned STARTUP_MS  = 600,
  parameter int unsigned BROWNOUT_US = 21_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_start_i,
  input  logic       line_ok_i,
  input  logic       line_high_i,
  input  logic       bulk_zero_i,
  input  logic       bias_hi_i,
  input  logic       bias_lo_i,
  output logic       drive_en_o,
  output logic       bias_fet_o,
  output logic [1:0] mode_o
);
  localparam longint unsigned START_CYC = time_to_cyc(CLK_HZ, STARTUP_MS, 1000);
  localparam longint unsigned BROWN_CYC = time_to_cyc(CLK_HZ, BROWNOUT_US, 1_000_000);
  localparam longint unsigned MAX_CYC   = (START_CYC > BROWN_CYC) ? START_CYC : BROWN_CYC;
  localparam int unsigned     TMR_W     = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] LIM_START = TMR_W'(START_CYC);
  localparam logic [TMR_W-1:0] LIM_BROWN = TMR_W'(BROWN_CYC);

  logic [FLAG_N-1:0] flag_raw, flag_s;
  logic              bias_ok, blocked, tmr_done, tmr_clr;
  logic [TMR_W-1:0]  tmr_lim;
  sup_mode_e         state_q, state_d;

  always_comb begin
    flag_raw            = '0;
    flag_raw[F_START]   = line_start_i;
    flag_raw[F_OK]      = line_ok_i;
    flag_raw[F_HIGH]    = line_high_i;
    flag_raw[F_BZERO]   = bulk_zero_i;
    flag_raw[F_BIAS_HI] = bias_hi_i;
    flag_raw[F_BIAS_LO] = bias_lo_i;
  end

  sup_sync #(.W(FLAG_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (flag_raw),
    .q_o   (flag_s)
  );

  sup_bias_hyst u_hyst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .above_hi_i(flag_s[F_BIAS_HI]),
    .above_lo_i(flag_s[F_BIAS_LO]),
    .ctrl_o    (bias_ok)
  );

  assign blocked = flag_s[F_HIGH] & flag_s[F_BZERO];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_IDLE:
        if (flag_s[F_START] && !blocked) state_d = MODE_START;
      MODE_START:
        if (bias_ok && flag_s[F_START] && !blocked) state_d = MODE_RUN;
        else if (tmr_done)                          state_d = MODE_IDLE;
      MODE_RUN:
        if (!flag_s[F_OK]) state_d = MODE_BROWN;
      MODE_BROWN:
        if (flag_s[F_OK])  state_d = MODE_RUN;
        else if (tmr_done) state_d = MODE_IDLE;
      default: state_d = MODE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= MODE_IDLE;
    else         state_q <= state_d;

  // timer restarts on every mode change; idle and run never time out
  assign tmr_clr = (state_d != state_q) || (state_q == MODE_IDLE) || (state_q == MODE_RUN);
  assign tmr_lim = (state_q == MODE_BROWN) ? LIM_BROWN : LIM_START;

  sup_timer #(.W(TMR_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tmr_clr),
    .lim_i (tmr_lim),
    .done_o(tmr_done)
  );

  assign drive_en_o = (state_q == MODE_RUN) || (state_q == MODE_BROWN);
  assign bias_fet_o = bias_ok;
  assign mode_o     = state_q;

  assert_blocked_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_IDLE && blocked) |=> (state_q == MODE_IDLE));
  assert_no_skip_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_IDLE) |=> (state_q != MODE_RUN));
  assert_run_needs_bias_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_START && !bias_ok) |=> (state_q != MODE_RUN));
  assert_sag_enters_brown_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_RUN && !flag_s[F_OK]) |=> (state_q == MODE_BROWN));
  assert_brown_recovers_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MODE_BROWN && flag_s[F_OK]) |=> (state_q == MODE_RUN));
  assert_drive_drop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_en_o) |-> (state_q == MODE_IDLE));
endmodule

// File: tb/start_supervisor_tb.sv
module start_supervisor_tb;
  localparam int unsigned CLK_HZ = 10_000;
  localparam int START_CYC = CLK_HZ * 600 / 1000;
  localparam int BROWN_CYC = CLK_HZ * 21 / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic line_start = 0, line_ok = 0, line_high = 0, bulk_zero = 0, bias_hi = 0, bias_lo = 0;
  logic drive_en, bias_fet;
  logic [1:0] mode;

  int tests = 0, fails = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  start_supervisor #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .line_start_i(line_start), .line_ok_i(line_ok), .line_high_i(line_high),
    .bulk_zero_i(bulk_zero), .bias_hi_i(bias_hi), .bias_lo_i(bias_lo),
    .drive_en_o(drive_en), .bias_fet_o(bias_fet), .mode_o(mode)
  );

  // behavioural reference: delayed flag history plus mode/timer/fet
  logic [5:0] hist[$];
  int m_mode = 0, m_cnt = 0;
  bit m_fet = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {6'b0, 6'b0};
      m_mode = 0; m_cnt = 0; m_fet = 0;
    end else begin
      logic [5:0] f;
      bit blk, done;
      int nxt, lim;
      f   = hist[0];
      blk = f[2] && f[3];
      lim = (m_mode == 3) ? BROWN_CYC : START_CYC;
      done = (m_cnt == lim - 1);
      nxt = m_mode;
      case (m_mode)
        0: if (f[0] && !blk) nxt = 1;
        1: if (m_fet && f[0] && !blk) nxt = 2; else if (done) nxt = 0;
        2: if (!f[1]) nxt = 3;
        3: if (f[1]) nxt = 2; else if (done) nxt = 0;
        default: nxt = 0;
      endcase
      if (nxt != m_mode || m_mode == 0 || m_mode == 2) m_cnt = 0; else m_cnt++;
      m_mode = nxt;
      if (f[4]) m_fet = 1; else if (!f[5]) m_fet = 0;
      void'(hist.pop_front());
      hist.push_back({bias_lo, bias_hi, bulk_zero, line_high, line_ok, line_start});
    end
  end

  always @(negedge clk) if (rst_n) begin
    tests++;
    if (mode != m_mode[1:0] || drive_en != (m_mode >= 2) || bias_fet != m_fet) begin
      fails++;
      $display("FAIL %s model: mode=%0d drive=%0b fet=%0b expected mode=%0d drive=%0b fet=%0b",
               cur_req, mode, drive_en, bias_fet, m_mode, (m_mode >= 2), m_fet);
    end
  end

  task automatic expect_out(input int em, input bit ed, input bit ef, input string req);
    tests++;
    if (mode != em[1:0] || drive_en != ed || bias_fet != ef) begin
      fails++;
      $display("FAIL %s: mode=%0d drive=%0b fet=%0b expected mode=%0d drive=%0b fet=%0b",
               req, mode, drive_en, bias_fet, em, ed, ef);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    expect_out(0, 0, 0, "R1");
    rst_n = 1'b1;
    step(2);
    expect_out(0, 0, 0, "R1");

    // R3: start blocked while line high and bulk zero
    cur_req = "R3";
    line_start = 1; line_ok = 1; line_high = 1; bulk_zero = 1;
    step(30);
    expect_out(0, 0, 0, "R3");
    // R2: release reaches the mode at the third edge
    cur_req = "R2";
    bulk_zero = 0;
    step(2);
    expect_out(0, 0, 0, "R2");
    step(1);
    expect_out(1, 0, 0, "R2");
    line_high = 0;

    // R4 hysteresis and R5 qualification
    cur_req = "R4";
    bias_lo = 1;
    step(5);
    expect_out(1, 0, 0, "R4");
    bias_hi = 1;
    step(3);
    expect_out(1, 0, 1, "R4");
    cur_req = "R5";
    step(1);
    expect_out(2, 1, 1, "R5");
    expect_out(2, 1, 1, "R10");
    cur_req = "R4";
    bias_hi = 0;
    step(5);
    expect_out(2, 1, 1, "R4");
    bias_lo = 0;
    step(3);
    expect_out(2, 1, 0, "R4");

    // R7, R9: long sag times out
    cur_req = "R7";
    line_ok = 0;
    step(3);
    expect_out(3, 1, 0, "R7");
    expect_out(3, 1, 0, "R10");
    cur_req = "R9";
    step(BROWN_CYC - 1);
    expect_out(3, 1, 0, "R9");
    step(1);
    expect_out(0, 0, 0, "R9");
    step(1);
    expect_out(1, 0, 0, "R6");

    // R6: start-up without bias times out and restarts
    cur_req = "R6";
    step(START_CYC - 1);
    expect_out(1, 0, 0, "R6");
    step(1);
    expect_out(0, 0, 0, "R6");
    step(1);
    expect_out(1, 0, 0, "R6");

    // R8: short sag recovers
    cur_req = "R8";
    line_ok = 1; bias_hi = 1; bias_lo = 1;
    step(10);
    expect_out(2, 1, 1, "R5");
    line_ok = 0;
    step(3);
    expect_out(3, 1, 1, "R7");
    step(50);
    line_ok = 1;
    step(2);
    expect_out(3, 1, 1, "R8");
    step(1);
    expect_out(2, 1, 1, "R8");

    // R10: removing start flag while running has no effect on drive
    cur_req = "R10";
    line_start = 0;
    step(10);
    expect_out(2, 1, 1, "R10");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule